// File: doc/BRIEF.md
# MFM Write Pulse Interval Encoder

This block turns a stream of data bytes into the write-data pulse train for a double-density magnetic disk. It does not build clock and data half-cells. It only decides how long to wait between one flux-transition pulse and the next. The wait is two, three or four microseconds. The choice depends on one remembered fact (whether the last pulse stood for a clock bit or a data bit) and on the next one or two data bits. Each pulse drives the active-low write line low for half a microsecond.

Bytes arrive over a valid/ready handshake and are consumed most significant bit first. The block also has a raw-interval command port. A sequencer uses it to lay down the preamble and the sync-mark pattern as explicit short, medium and long spacings, then hands over to the byte port without a break. The handshakes are accepted only at decision points: when the encoder is idle, or in the cycle in which the pending interval expires and its pulse starts. Anything queued ahead of the stream therefore chains with no gap.

Top module: `mfm_pulse_encoder`

## Requirements
- R1: After reset `wd_n` is high, `underrun` is low, the remembered pulse type is "data", and both ready outputs are high. No pulse appears until a byte or a raw command has been accepted.
- R2: Every pulse holds `wd_n` low for exactly CYC_PER_US/2 clock cycles, which is 0.5 us. Between two pulses `wd_n` stays high for at least 1.5 us.
- R3: If the remembered type is "clock" and the next bit is 0, the next pulse comes 2 us after the previous one, and the type stays "clock".
- R4: If the remembered type is "clock" and the next bit is 1, the interval is 3 us and the type becomes "data".
- R5: If the remembered type is "data" and the next bit is 1, the interval is 2 us and the type stays "data".
- R6: If the remembered type is "data" and the next bit is 0, the bit after it is also consumed. The interval is 3 us with new type "clock" when that second bit is 0, and 4 us with new type "data" when it is 1. The second bit may be the MSB of the following byte.
- R7: Bits of each byte are consumed from bit 7 down to bit 0.
- R8: An accepted raw command produces one pulse after an interval set by `raw_span`: 0 gives 2 us, 1 gives 3 us, 2 and 3 give 4 us. It leaves the remembered type and any bits still pending unchanged. While `raw_valid` is high, it takes priority over data and `in_ready` stays low.
- R9: A decision (accepting a byte, using held bits, or accepting a raw command) happens only when the encoder is idle or in the cycle in which a pending interval expires. The pulse for that decision falls exactly its interval in clock cycles after the decision edge, and `in_ready` is never high without `raw_ready`.
- R10: A data-type lookahead can fall on the last held bit while pulses are running and no byte is offered. In that case the encoder raises `underrun` for exactly one cycle, starting at the same edge as the pulse it was due to follow, and resolves the pending 0 as 3 us with new type "clock".
- R11: When a pulse starts and no work is available, the encoder goes idle with `wd_n` high after the pulse. It restarts on the next accepted item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data byte offered |
| in_data | input | DATA_W | Data byte, MSB consumed first |
| in_ready | output | 1 | Byte accepted at this edge when in_valid is high |
| raw_valid | input | 1 | Raw interval command offered |
| raw_span | input | 2 | Raw interval code: 0=2 us, 1=3 us, 2/3=4 us |
| raw_ready | output | 1 | Raw command accepted at this edge when raw_valid is high |
| wd_n | output | 1 | Active-low write-data pulse line |
| underrun | output | 1 | One-cycle flag: lookahead bit missing, resolved as 0 |

## Verification
The only internal state is the one remembered pulse type, the held bits and the interval counter. A wrong value in any of these shows at the ports no later than the next falling edge of `wd_n`, as an interval that is off by a whole microsecond or more. Because the bench predicts every interval from its own model of the bit stream, a flipped pulse type, a bit consumed in the wrong order or a counter that is off by one cycle all show up as a mismatched spacing within one or two pulses. A raw command that disturbs the remembered type shows up only on the first data pulse after it, so the bench always follows raw commands with data.

// File: rtl/mfmw_pkg.sv
`timescale 1ns/1ps
package mfmw_pkg;

    // Pulse-to-pulse spacing in whole microseconds
    typedef enum logic [1:0] {
        SPAN_2US = 2'd0,
        SPAN_3US = 2'd1,
        SPAN_4US = 2'd2
    } span_e;

    // Raw command code to spacing; the spare code maps to the longest spacing
    function automatic span_e span_from_code(input logic [1:0] code);
        case (code)
            2'd0:    return SPAN_2US;
            2'd1:    return SPAN_3US;
            default: return SPAN_4US;
        endcase
    endfunction

endpackage

// File: rtl/mfmw_bit_picker.sv
`timescale 1ns/1ps
// Decision logic: picks the next spacing from the held bits, the offered
// byte and the remembered pulse type. Purely combinational.
module mfmw_bit_picker
    import mfmw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LW     = 4
) (
    input  logic [DATA_W-1:0] sh,
    input  logic [LW-1:0]     left,
    input  logic              prev_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              running,
    input  logic              raw_valid,
    input  logic [1:0]        raw_code,
    output logic              need_byte,
    output logic              go,
    output logic              underrun,
    output span_e             span,
    output logic [DATA_W-1:0] sh_nx,
    output logic [LW-1:0]     left_nx,
    output logic              prev_nx
);

    logic [DATA_W-1:0] src;
    logic [LW-1:0]     src_left;
    logic              use_src;
    logic              fb;
    logic              sb;
    logic              pair;

    always_comb begin
        // A byte is needed when nothing is held, or when the last held bit
        // is a 0 after a data pulse (lookahead into the next byte)
        need_byte = (left == '0) ||
                    ((left == LW'(1)) && prev_data && !sh[DATA_W-1]);

        go       = 1'b0;
        underrun = 1'b0;
        span     = SPAN_2US;
        sh_nx    = sh;
        left_nx  = left;
        prev_nx  = prev_data;
        src      = sh;
        src_left = left;
        use_src  = 1'b0;
        fb       = 1'b0;
        sb       = 1'b0;
        pair     = 1'b0;

        if (raw_valid) begin
            go   = 1'b1;
            span = span_from_code(raw_code);
        end else if (left == '0) begin
            if (in_valid) begin
                src      = in_data;
                src_left = LW'(DATA_W);
                use_src  = 1'b1;
            end
        end else if (need_byte) begin
            if (in_valid) begin
                go      = 1'b1;
                span    = in_data[DATA_W-1] ? SPAN_4US : SPAN_3US;
                prev_nx = in_data[DATA_W-1];
                sh_nx   = in_data << 1;
                left_nx = LW'(DATA_W - 1);
            end else if (running) begin
                underrun = 1'b1;
                go       = 1'b1;
                span     = SPAN_3US;
                prev_nx  = 1'b0;
                sh_nx    = '0;
                left_nx  = '0;
            end
        end else begin
            use_src = 1'b1;
        end

        if (use_src) begin
            go = 1'b1;
            fb = src[DATA_W-1];
            sb = src[DATA_W-2];
            if (!prev_data) begin
                span    = fb ? SPAN_3US : SPAN_2US;
                prev_nx = fb;
            end else if (fb) begin
                span    = SPAN_2US;
                prev_nx = 1'b1;
            end else begin
                pair    = 1'b1;
                span    = sb ? SPAN_4US : SPAN_3US;
                prev_nx = sb;
            end
            sh_nx   = pair ? (src << 2) : (src << 1);
            left_nx = pair ? (src_left - LW'(2)) : (src_left - LW'(1));
        end
    end

endmodule

// File: rtl/mfmw_pulse_timer.sv
`timescale 1ns/1ps
// Interval counter and pulse former. A load starts an interval; when it
// expires the write line is pulled low for half a microsecond.
module mfmw_pulse_timer
    import mfmw_pkg::*;
#(
    parameter int CYC_PER_US = 50
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  span_e span,
    output logic  running,
    output logic  fire,
    output logic  wd_n
);

    localparam int MAX_IV    = 4 * CYC_PER_US;
    localparam int CW        = $clog2(MAX_IV + 1);
    localparam int PULSE_CYC = CYC_PER_US / 2;
    localparam int PW        = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
        logic          low;
        logic [PW-1:0] pcnt;
    } tm_t;

    tm_t           tm_q, tm_d;
    logic [CW-1:0] span_cyc;

    always_comb begin
        case (span)
            SPAN_2US: span_cyc = CW'(2 * CYC_PER_US);
            SPAN_3US: span_cyc = CW'(3 * CYC_PER_US);
            default:  span_cyc = CW'(4 * CYC_PER_US);
        endcase

        tm_d = tm_q;
        fire = tm_q.run && (tm_q.cnt == '0);

        if (tm_q.low) begin
            if (tm_q.pcnt == '0) tm_d.low  = 1'b0;
            else                 tm_d.pcnt = tm_q.pcnt - PW'(1);
        end
        if (tm_q.run && (tm_q.cnt != '0)) tm_d.cnt = tm_q.cnt - CW'(1);
        if (fire) begin
            tm_d.run  = 1'b0;
            tm_d.low  = 1'b1;
            tm_d.pcnt = PW'(PULSE_CYC - 1);
        end
        if (load) begin
            tm_d.run = 1'b1;
            tm_d.cnt = span_cyc - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign running = tm_q.run;
    assign wd_n    = !tm_q.low;

endmodule

// File: rtl/mfm_pulse_encoder.sv
`timescale 1ns/1ps
module mfm_pulse_encoder
    import mfmw_pkg::*;
#(
    parameter int CYC_PER_US      = 50,
    parameter int DATA_W          = 8,
    parameter bit RESET_PREV_DATA = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              raw_valid,
    input  logic [1:0]        raw_span,
    output logic              raw_ready,
    output logic              wd_n,
    output logic              underrun
);

    localparam int LW = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [LW-1:0]     left;
        logic              prev;
        logic              und;
    } st_t;

    st_t               st_q, st_d;
    logic              need_byte;
    logic              go;
    logic              pick_un;
    span_e             span;
    logic [DATA_W-1:0] sh_nx;
    logic [LW-1:0]     left_nx;
    logic              prev_nx;
    logic              running;
    logic              fire;
    logic              dp;
    logic              commit;

    mfmw_bit_picker #(
        .DATA_W (DATA_W),
        .LW     (LW)
    ) u_pick (
        .sh        (st_q.sh),
        .left      (st_q.left),
        .prev_data (st_q.prev),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .running   (running),
        .raw_valid (raw_valid),
        .raw_code  (raw_span),
        .need_byte (need_byte),
        .go        (go),
        .underrun  (pick_un),
        .span      (span),
        .sh_nx     (sh_nx),
        .left_nx   (left_nx),
        .prev_nx   (prev_nx)
    );

    mfmw_pulse_timer #(
        .CYC_PER_US (CYC_PER_US)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (commit),
        .span    (span),
        .running (running),
        .fire    (fire),
        .wd_n    (wd_n)
    );

    always_comb begin
        dp        = !running || fire;
        commit    = dp && go;
        raw_ready = dp;
        in_ready  = dp && !raw_valid && need_byte;

        st_d     = st_q;
        st_d.und = commit && pick_un;
        if (commit) begin
            st_d.sh   = sh_nx;
            st_d.left = left_nx;
            st_d.prev = prev_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sh   <= '0;
            st_q.left <= '0;
            st_q.prev <= RESET_PREV_DATA;
            st_q.und  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign underrun = st_q.und;

endmodule

// File: rtl/mfm_pulse_encoder_chk.sv
`timescale 1ns/1ps
module mfm_pulse_encoder_chk #(
    parameter int CYC_PER_US = 50
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic raw_valid,
    input logic raw_ready,
    input logic wd_n,
    input logic underrun
);

    localparam int PULSE_CYC = CYC_PER_US / 2;
    localparam int GAP_MIN   = 3 * PULSE_CYC;

    logic [15:0] lo_q;
    logic [15:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= wd_n ? 16'd0 : ((lo_q == 16'hFFFF) ? lo_q : lo_q + 16'd1);
            hi_q <= !wd_n ? 16'd0 : ((hi_q == 16'hFFFF) ? hi_q : hi_q + 16'd1);
        end
    end

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_n |-> (lo_q < 16'(PULSE_CYC)));

    // R2
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_n && (lo_q == 16'd0)) |-> (hi_q >= 16'(GAP_MIN)));

    // R8
    raw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> !in_ready);

    // R9
    ready_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> raw_ready);

    // R10
    und_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !wd_n);

    // R10
    und_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

endmodule

bind mfm_pulse_encoder mfm_pulse_encoder_chk #(
    .CYC_PER_US (CYC_PER_US)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .raw_valid (raw_valid),
    .raw_ready (raw_ready),
    .wd_n      (wd_n),
    .underrun  (underrun)
);

// File: tb/mfm_pulse_encoder_test.sv
`timescale 1ns/1ps
module mfm_pulse_encoder_test;

    localparam int C = 50;
    localparam int P = C / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       raw_valid = 1'b0;
    logic [1:0] raw_span = 2'd0;
    logic       raw_ready;
    logic       wd_n;
    logic       underrun;

    mfm_pulse_encoder #(.CYC_PER_US(C), .DATA_W(8), .RESET_PREV_DATA(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .raw_valid(raw_valid), .raw_span(raw_span),
        .raw_ready(raw_ready), .wd_n(wd_n), .underrun(underrun)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    // pulse monitor
    int pt[64];
    int pw[64];
    int np = 0;
    int nw = 0;
    int n_un = 0;
    int ut = 0;
    int t_fall = 0;
    logic wd_prev = 1'b1;

    always @(negedge clk) begin
        if (wd_prev && !wd_n) begin
            if (np < 64) pt[np] = cyc;
            np++;
            t_fall = cyc;
        end
        if (!wd_prev && wd_n) begin
            if (nw < 64) pw[nw] = cyc - t_fall;
            nw++;
        end
        if (underrun) begin
            ut = cyc;
            n_un++;
        end
        wd_prev = wd_n;
    end

    // reference model
    logic [7:0] bq[16];
    int  exp_iv[64];
    int  ne;
    int  exp_un;
    bit  m_prev = 1'b1;
    bit  mb[128];

    task automatic check_eq(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic model(input int nbytes);
        int nbits;
        int i;
        nbits = nbytes * 8;
        for (int b = 0; b < nbytes; b++)
            for (int j = 0; j < 8; j++) mb[b*8+j] = bq[b][7-j];
        ne = 0;
        exp_un = -1;
        i = 0;
        while (i < nbits) begin
            if (!m_prev) begin
                exp_iv[ne] = mb[i] ? 3*C : 2*C;
                m_prev = mb[i];
                i++;
            end else if (mb[i]) begin
                exp_iv[ne] = 2*C;
                i++;
            end else if (i + 1 < nbits) begin
                exp_iv[ne] = mb[i+1] ? 4*C : 3*C;
                m_prev = mb[i+1];
                i += 2;
            end else begin
                exp_iv[ne] = 3*C;
                m_prev = 1'b0;
                exp_un = ne;
                i++;
            end
            ne++;
        end
    endtask

    task automatic clear_mon();
        np = 0; nw = 0; n_un = 0;
    endtask

    task automatic push_byte(input logic [7:0] b, output int t_acc);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        t_acc = cyc + 1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push_raw(input logic [1:0] code, output int t_acc, output logic saw_in_ready);
        raw_valid = 1'b1;
        raw_span  = code;
        while (!raw_ready) @(negedge clk);
        saw_in_ready = in_ready;
        t_acc = cyc + 1;
        @(negedge clk);
        raw_valid = 1'b0;
    endtask

    task automatic verify(input string tag, input int t0);
        check_eq({tag, " pulse count"}, np, ne);
        for (int i = 0; i < ne && i < np && i < 64; i++)
            check_eq($sformatf("%s interval %0d", tag, i),
                     (i == 0) ? pt[0] - t0 : pt[i] - pt[i-1], exp_iv[i]);
        for (int i = 0; i < nw && i < 64; i++)
            check_eq($sformatf("R2 pulse width %0d", i), pw[i], P);
        if (exp_un >= 0) begin
            check_eq({tag, " R10 underrun count"}, n_un, 1);
            if (exp_un > 0 && exp_un <= np)
                check_eq({tag, " R10 underrun cycle"}, ut, pt[exp_un-1]);
        end else begin
            check_eq({tag, " R10 no underrun"}, n_un, 0);
        end
        // R11: idle afterwards
        check_eq({tag, " R11 idle wd_n"}, int'(wd_n), 1);
        check_eq({tag, " R11 idle raw_ready"}, int'(raw_ready), 1);
    endtask

    task automatic run_bytes(input string tag, input int nbytes);
        int t0;
        int t;
        clear_mon();
        model(nbytes);
        t0 = 0;
        for (int i = 0; i < nbytes; i++) begin
            push_byte(bq[i], t);
            if (i == 0) t0 = t;
        end
        repeat (2200) @(negedge clk);
        verify(tag, t0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check_eq("R1 wd_n in reset", int'(wd_n), 1);
        check_eq("R1 underrun in reset", int'(underrun), 0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        check_eq("R1 wd_n idle", int'(wd_n), 1);
        check_eq("R1 in_ready idle", int'(in_ready), 1);
        check_eq("R1 raw_ready idle", int'(raw_ready), 1);
        check_eq("R1 no pulse before input", np, 0);
    endtask

    task automatic test_raw();
        int t0;
        int t;
        logic r;
        clear_mon();
        ne = 4; exp_un = -1;
        exp_iv[0] = 2*C; exp_iv[1] = 3*C; exp_iv[2] = 4*C; exp_iv[3] = 4*C;
        push_raw(2'd0, t0, r);
        push_raw(2'd1, t, r);
        push_raw(2'd2, t, r);
        push_raw(2'd3, t, r);
        repeat (1000) @(negedge clk);
        verify("R8 raw spans", t0);
    endtask

    task automatic test_raw_preempt();
        int t0;
        int t1;
        logic r;
        clear_mon();
        bq[0] = 8'hF0;
        model(1);
        for (int i = ne; i > 1; i--) exp_iv[i] = exp_iv[i-1];
        exp_iv[1] = 2*C;
        ne++;
        push_byte(bq[0], t0);
        push_raw(2'd0, t1, r);
        check_eq("R8 in_ready low under raw", int'(r), 0);
        repeat (2200) @(negedge clk);
        verify("R8 raw between data bits", t0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        test_raw();
        // R5 R6 R7: from data type, mixed pattern
        bq[0] = 8'hA1;
        run_bytes("R5 R6 R7 byte A1", 1);
        // R3 R4: runs of zeros then ones
        bq[0] = 8'h00; bq[1] = 8'hFF;
        run_bytes("R3 R4 bytes 00 FF", 2);
        // R6: lookahead reaches into the next byte
        bq[0] = 8'h02; bq[1] = 8'h80; bq[2] = 8'h4E;
        run_bytes("R6 cross byte", 3);
        // R7: order within a byte
        bq[0] = 8'h0F; bq[1] = 8'h35;
        run_bytes("R7 msb first", 2);
        // R10 R11: missing lookahead byte
        bq[0] = 8'h02;
        run_bytes("R10 underrun", 1);
        test_raw_preempt();
        // state after raw commands must still follow the data rules (R8)
        bq[0] = 8'h5A;
        run_bytes("R8 state kept", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule